// File: doc/BRIEF.md
# Transmit Training Request Controller

This block owns the request that makes a serial transmitter send training patterns. It is meant for links that may have no return path. The request output `force_train` comes out of a register and is high whenever the transmitter should be training. It is set on reset exit, on a relink pulse, and whenever the transceiver reset-done flag is low.

Once the transceiver has finished its reset, the request is dropped in one of two ways:

- **Remote status present.** If a qualified lock report from the far receiver exists, only that report can release the request.
- **No remote status.** A hold timer with a programmable terminal count releases the request when it expires. Software sets the count long enough to cover the transceiver reset sequence.

After release the request stays low. It is raised again only when the link is declared lost, either through the relink pulse or because the transceiver goes back into reset.

Top module: `train_req_ctrl`

## Requirements
- R1: `force_train` is 1 in the cycle after any clock edge that samples `rst` high. It is therefore also 1 on the first cycle after reset is released.
- R2: Take `N` as the value of `hold_count`. With `remote_status_valid` low, `force_train` stays 1 after the first N qualifying edges and is 0 after the (N+1)th. A qualifying edge is one at which `xcvr_rst_done` is 1, counted from reset exit or from the last restart. N = 0 releases at the first qualifying edge.
- R3: An edge that samples `xcvr_rst_done`, `remote_status_valid` and `remote_locked` all at 1, with `relink_req` at 0, leaves `force_train` at 0.
- R4: An edge that samples `relink_req` at 1 leaves `force_train` at 1 and restarts the hold count from zero. This takes priority over any release condition in the same cycle.
- R5: While `remote_status_valid` is 1 and `remote_locked` is 0, `force_train` stays 1 no matter how long the hold count has run.
- R6: An edge that samples `xcvr_rst_done` at 0 leaves `force_train` at 1 and clears the hold count. Counting starts again only once `xcvr_rst_done` returns to 1.
- R7: Once `force_train` is 0, it stays 0 until `relink_req` is sampled at 1 or `xcvr_rst_done` is sampled at 0. Changes on `remote_locked`, `remote_status_valid` and `hold_count` have no effect on it.
- R8: Edges at which `remote_status_valid` is 1 neither advance nor clear the hold count. When the qualifier returns low, counting resumes from the value already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xcvr_rst_done | input | 1 | Transceiver reset sequence complete |
| remote_status_valid | input | 1 | Far-end lock report is available |
| remote_locked | input | 1 | Far-end receiver reports lock (used only when qualified) |
| relink_req | input | 1 | Link-lost pulse; reasserts the request and restarts the hold count |
| hold_count | input | TW (32) | Hold timer terminal count, unsigned |
| force_train | output | 1 | Request to the transmitter to send training patterns |

## Verification
Every result appears one edge after the stimulus that causes it, because `force_train` is the only output and it is registered straight from the next-state decision. The exception is the timer release, which lands exactly N+1 qualifying edges after reset exit or a restart.

The bench drives inputs one time unit after a rising edge and samples `force_train` one time unit after the following edge. It walks a cycle counter against the arithmetic expectation `k <= N`, over sweeps of N, of reset-done delay, and of a remote-status pause inserted part way through the count. That way, both an early release and a late release of a single cycle are caught.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [0:0] {
    ST_TRAIN    = 1'b0,
    ST_RELEASED = 1'b1
  } trc_state_t;
endpackage

// File: rtl/trc_hold_timer.sv
module trc_hold_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          advance,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] cnt;

  // Saturating up-counter: holds once it reaches the terminal count
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (advance && !expired) begin
      cnt <= cnt + ONE;
    end
  end

  assign expired = (cnt >= limit);
endmodule

// File: rtl/trc_release_logic.sv
module trc_release_logic
  import trc_pkg::*;
(
  input  trc_state_t state,
  input  logic       rst_done,
  input  logic       rs_valid,
  input  logic       r_locked,
  input  logic       relink,
  input  logic       expired,
  output trc_state_t nxt_state,
  output logic       tmr_clear,
  output logic       tmr_adv
);
  always_comb begin
    nxt_state = state;
    tmr_clear = 1'b0;
    tmr_adv   = 1'b0;
    if (relink) begin
      // link lost: train again from scratch
      nxt_state = ST_TRAIN;
      tmr_clear = 1'b1;
    end else if (!rst_done) begin
      // transceiver (back) in reset: hold request, restart hold period
      nxt_state = ST_TRAIN;
      tmr_clear = 1'b1;
    end else if (state == ST_TRAIN) begin
      if (rs_valid) begin
        // qualified far-end status overrides the timer; count frozen
        if (r_locked) nxt_state = ST_RELEASED;
      end else if (expired) begin
        nxt_state = ST_RELEASED;
      end else begin
        tmr_adv = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trc_state_reg.sv
module trc_state_reg
  import trc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  trc_state_t nxt_state,
  output trc_state_t state,
  output logic       train_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_TRAIN;
      train_q <= 1'b1;
    end else begin
      state   <= nxt_state;
      train_q <= (nxt_state == ST_TRAIN);
    end
  end
endmodule

// File: rtl/train_req_ctrl.sv
module train_req_ctrl
  import trc_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xcvr_rst_done,
  input  logic          remote_status_valid,
  input  logic          remote_locked,
  input  logic          relink_req,
  input  logic [TW-1:0] hold_count,
  output logic          force_train
);
  trc_state_t state;
  trc_state_t nxt_state;
  logic       tmr_clear;
  logic       tmr_adv;
  logic       tmr_expired;

  trc_hold_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .advance (tmr_adv),
    .limit   (hold_count),
    .expired (tmr_expired)
  );

  trc_release_logic u_decide (
    .state     (state),
    .rst_done  (xcvr_rst_done),
    .rs_valid  (remote_status_valid),
    .r_locked  (remote_locked),
    .relink    (relink_req),
    .expired   (tmr_expired),
    .nxt_state (nxt_state),
    .tmr_clear (tmr_clear),
    .tmr_adv   (tmr_adv)
  );

  trc_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .state     (state),
    .train_q   (force_train)
  );
endmodule

// File: rtl/trc_checker.sv
module trc_checker (
  input logic clk,
  input logic rst,
  input logic xcvr_rst_done,
  input logic remote_status_valid,
  input logic remote_locked,
  input logic relink_req,
  input logic force_train
);
  AST_RESET_EXIT_TRAIN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> force_train); // R1

  AST_REMOTE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (xcvr_rst_done && remote_status_valid && remote_locked && !relink_req) |=> !force_train); // R3

  AST_RELINK_RAISES: assert property (@(posedge clk) disable iff (rst)
    relink_req |=> force_train); // R4

  AST_TIMER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (force_train && remote_status_valid && !remote_locked) |=> force_train); // R5

  AST_RSTDONE_LOW_RAISES: assert property (@(posedge clk) disable iff (rst)
    !xcvr_rst_done |=> force_train); // R6

  AST_RELEASE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!force_train && xcvr_rst_done && !relink_req) |=> !force_train); // R7
endmodule

bind train_req_ctrl trc_checker u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .xcvr_rst_done       (xcvr_rst_done),
  .remote_status_valid (remote_status_valid),
  .remote_locked       (remote_locked),
  .relink_req          (relink_req),
  .force_train         (force_train)
);

// File: tb/sim_train_req_ctrl.sv
module sim_train_req_ctrl;
  localparam int  TW     = 32;
  localparam time PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rdone = 1'b0;
  logic          rvalid = 1'b0;
  logic          rlock = 1'b0;
  logic          relink = 1'b0;
  logic [TW-1:0] hold = '0;
  logic          ft;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  train_req_ctrl #(.TW(TW)) u0 (
    .clk(clk), .rst(rst), .xcvr_rst_done(rdone),
    .remote_status_valid(rvalid), .remote_locked(rlock),
    .relink_req(relink), .hold_count(hold), .force_train(ft)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic exp, input string req);
    n_vec++;
    if (ft !== exp) begin
      n_bad++;
      $display("FAIL %s: force_train=%b expected %b at %0t", req, ft, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; relink = 1'b0;
    cyc();
    chk(1'b1, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    cyc();
    // R2 / R7: timer release sweep
    for (int n = 0; n < 8; n++) begin
      hold = TW'(n); rdone = 1'b1; rvalid = 1'b0; rlock = 1'b0;
      do_reset();
      chk(1'b1, "R1");
      for (int k = 1; k <= n + 1; k++) begin
        cyc();
        chk(k <= n, "R2");
      end
      rlock = 1'b1; rvalid = 1'b1; hold = '1;
      for (int k = 0; k < 3; k++) begin
        cyc();
        chk(1'b0, "R7");
      end
      rvalid = 1'b0; rlock = 1'b0;
    end

    // R6: reset-done delay before counting starts
    for (int d = 0; d < 5; d++) begin
      hold = TW'(3); rdone = 1'b0;
      do_reset();
      for (int k = 0; k < d; k++) begin
        cyc();
        chk(1'b1, "R6");
      end
      rdone = 1'b1;
      for (int k = 1; k <= 4; k++) begin
        cyc();
        chk(k <= 3, "R6");
      end
    end

    // R4: relink restarts the hold count
    for (int n = 0; n < 6; n++) begin
      hold = TW'(n); rdone = 1'b1;
      do_reset();
      for (int k = 0; k <= n; k++) cyc();
      chk(1'b0, "R2");
      relink = 1'b1;
      cyc();
      chk(1'b1, "R4");
      relink = 1'b0;
      for (int k = 1; k <= n + 1; k++) begin
        cyc();
        chk(k <= n, "R4");
      end
    end

    // R6: reset-done drop after release
    hold = TW'(2); rdone = 1'b1;
    do_reset();
    for (int k = 0; k < 3; k++) cyc();
    chk(1'b0, "R2");
    rdone = 1'b0;
    cyc(); chk(1'b1, "R6");
    cyc(); chk(1'b1, "R6");
    rdone = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      cyc();
      chk(k <= 2, "R6");
    end

    // R5 / R3: remote status overrides timer
    hold = '0; rdone = 1'b1; rvalid = 1'b1; rlock = 1'b0;
    do_reset();
    for (int k = 0; k < 10; k++) begin
      cyc();
      chk(1'b1, "R5");
    end
    rlock = 1'b1;
    cyc(); chk(1'b0, "R3");
    rlock = 1'b0;
    cyc(); chk(1'b0, "R7");
    rvalid = 1'b0;
    cyc(); chk(1'b0, "R7");

    // R3: remote lock release needs reset done
    rdone = 1'b0; rvalid = 1'b1; rlock = 1'b1; hold = '0;
    do_reset();
    cyc(); chk(1'b1, "R6");
    rdone = 1'b1;
    cyc(); chk(1'b0, "R3");

    // R4: relink beats remote lock in the same cycle
    rdone = 1'b1; rvalid = 1'b1; rlock = 1'b1;
    relink = 1'b1;
    cyc(); chk(1'b1, "R4");
    relink = 1'b0;
    cyc(); chk(1'b0, "R3");

    // R8: remote-status pause freezes the count
    for (int p = 1; p < 5; p++) begin
      hold = TW'(4); rdone = 1'b1; rvalid = 1'b0; rlock = 1'b0;
      do_reset();
      cyc(); chk(1'b1, "R8");
      cyc(); chk(1'b1, "R8");
      rvalid = 1'b1;
      for (int k = 0; k < p; k++) begin
        cyc();
        chk(1'b1, "R8");
      end
      rvalid = 1'b0;
      for (int k = 1; k <= 3; k++) begin
        cyc();
        chk(k <= 2, "R8");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule